// File: doc/BRIEF.md
# Round-to-Odd Double-to-Single Narrowing Unit

This block narrows binary64 floating-point values to binary32 using round-to-odd. Round-to-odd cuts off the extra fraction bits. If any bit that was cut off is nonzero, it sets the lowest kept fraction bit to one. A value narrowed this way can later be narrowed again, with any rounding mode, and the result matches a single direct rounding. The two steps never round twice in a way that changes the answer.

A 128-bit source carries two binary64 lanes. Lane e sits at source bits [64e+63:64e]. In vector mode both lanes are narrowed. The two 32-bit results are packed as a 64-bit group, with result lane e at offset 32e inside the group. That group is written either to the low half of the destination, with the high half cleared, or to the high half, with the low half kept from the old destination value. In scalar mode only lane 0 is narrowed, into destination bits [31:0]. The other 96 bits are cleared, or kept when the merge control is set.

An operation is started with a one-cycle `inValid` pulse. On the next cycle the result appears on `dstOut` and `outValid` is high. The exception flags are sticky and only reset clears them.

Top module: `narrow_rto_unit`

## Requirements
- R1: Reset drives `dstOut` to zero, `outValid` low and all four flags low.
- R2: For a finite input inside the binary32 normal range, the exponent is rebiased and the top 23 fraction bits are kept. If any of the 29 dropped fraction bits is set, result bit 0 is forced to 1 and the inexact flag is raised. The result is never rounded up in magnitude.
- R3: An exactly representable normal input converts with no flag raised, including the largest finite binary32 value.
- R4: A finite input whose magnitude is at least 2^128 produces the largest finite binary32 value (exponent field 0xFE, fraction all ones) with the input's sign. It raises both overflow and inexact.
- R5: An input below 2^-126 in magnitude is shifted into a binary32 subnormal, and the bits shifted out are collected as sticky, then rounded to odd. Underflow and inexact are raised only when that result is inexact. An exact tiny result raises nothing.
- R6: A binary64 subnormal input, or any input too small to reach the lowest subnormal bit, yields the smallest subnormal (fraction 1) with its sign, plus underflow and inexact.
- R7: Any NaN input (exponent all ones, fraction nonzero) yields a NaN with the same sign, exponent 0xFF, fraction bit 22 set and fraction bits [21:0] equal to input fraction bits [50:29]. The invalid flag is raised only when input fraction bit 51 is clear (signaling NaN).
- R8: Infinities and zeros convert to the same class and sign with no flag raised.
- R9: In vector mode with `upperHalf` low, destination bits [63:0] receive the results of lanes 1 and 0, and bits [127:64] become zero.
- R10: In vector mode with `upperHalf` high, destination bits [127:64] receive the results and bits [63:0] keep the value on `dstOld`.
- R11: In scalar mode, bits [31:0] receive lane 0's result. Bits [127:32] are zero when `mergeScalar` is low and equal `dstOld` when it is high. Lane 1 and `upperHalf` have no effect on either the destination or the flags.
- R12: `outValid` rises exactly one cycle after an `inValid` pulse. `dstOut` holds its value while no new operation is issued.
- R13: Flags accumulate across operations: once a flag is raised it stays raised until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Start a conversion with the current inputs |
| srcVec | input | 128 | Two binary64 source lanes |
| dstOld | input | 128 | Present destination value, used for kept bits |
| scalarMode | input | 1 | 1: convert lane 0 only; 0: convert both lanes |
| upperHalf | input | 1 | Vector mode: write results to the upper half |
| mergeScalar | input | 1 | Scalar mode: keep bits [127:32] of the destination |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| dstOut | output | 128 | New destination value |
| flagInvalid | output | 1 | Sticky invalid-operation flag |
| flagOverflow | output | 1 | Sticky overflow flag |
| flagUnderflow | output | 1 | Sticky underflow flag |
| flagInexact | output | 1 | Sticky inexact flag |

## Verification
The bench aims at the fraction boundary, where a set bit just above the cut must stay exact while a set bit just below must flip bit 0. A design that rounds to nearest, or that ignores the sticky bits, returns an even fraction there. It also probes the edges of the exponent range: 2^128 must saturate to the largest finite value rather than infinity, and the values 2^-149, 2^-150 and one just under 2^-126 test the denormalizing shift. A shifter that is off by one, or that loses the sticky bits, produces zero or the wrong fraction. Signaling and quiet NaNs check the payload and the invalid flag, and the placement tests catch a design that clobbers kept destination bits or lets lane 1 leak into a scalar result.

// File: rtl/rto_pkg.sv
package rto_pkg;
  // binary64 source format
  localparam int D_EXP_W = 11;
  localparam int D_MAN_W = 52;
  localparam int D_W     = 1 + D_EXP_W + D_MAN_W;
  localparam int D_BIAS  = (1 << (D_EXP_W - 1)) - 1;
  // binary32 result format
  localparam int S_EXP_W = 8;
  localparam int S_MAN_W = 23;
  localparam int S_W     = 1 + S_EXP_W + S_MAN_W;
  localparam int S_BIAS  = (1 << (S_EXP_W - 1)) - 1;
  // derived conversion constants
  localparam int DROP_W     = D_MAN_W - S_MAN_W;           // 29 dropped bits
  localparam int REBIAS     = D_BIAS - S_BIAS;             // 896
  localparam int OVF_EXP    = REBIAS + (1 << S_EXP_W) - 1; // 1151
  localparam int SUB_BASE   = REBIAS + 1 + DROP_W + 0;     // 926 - 1 offset below
  localparam int SHIFT_BASE = SUB_BASE + 1;                // 927 - 1 = 926 used as e-dist
  localparam int SIG_W      = D_MAN_W + 1;
  localparam int WIDE_W     = 64;
  localparam int SH_W       = $clog2(WIDE_W);
  localparam int SH_MAX     = WIDE_W - 1;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fpFlags_t;

  typedef struct packed {
    logic captureRes;
    logic accumFlags;
  } ctrlStrobes_t;
endpackage

// File: rtl/fp_narrow_lane.sv
module fp_narrow_lane
  import rto_pkg::*;
(
  input  logic [D_W-1:0] srcVal,
  output logic [S_W-1:0] resVal,
  output fpFlags_t       laneFlags
);
  logic               signBit;
  logic [D_EXP_W-1:0] expIn;
  logic [D_MAN_W-1:0] manIn;
  logic [D_EXP_W:0]   expWide;
  logic [D_EXP_W:0]   shiftDist;
  logic [SH_W-1:0]    shAmt;
  logic [WIDE_W-1:0]  wideSig;
  logic [WIDE_W-1:0]  dropMask;
  logic [S_MAN_W-1:0] subFrac;
  logic               subSticky;
  logic               normSticky;
  logic [D_EXP_W:0]   normExp;

  assign signBit = srcVal[D_W-1];
  assign expIn   = srcVal[D_W-2 -: D_EXP_W];
  assign manIn   = srcVal[D_MAN_W-1:0];
  assign expWide = {1'b0, expIn};

  // Subnormal path: distance from the subnormal alignment point, clamped
  assign shiftDist = (D_EXP_W+1)'(SHIFT_BASE - 1) - expWide;
  assign shAmt = (shiftDist > (D_EXP_W+1)'(SH_MAX)) ? SH_W'(SH_MAX) : shiftDist[SH_W-1:0];
  assign wideSig  = {{(WIDE_W-SIG_W){1'b0}}, (expIn != '0), manIn};
  assign dropMask = (WIDE_W'(1) << shAmt) - WIDE_W'(1);
  assign subFrac  = S_MAN_W'(wideSig >> shAmt);
  assign subSticky = |(wideSig & dropMask);

  // Normal path
  assign normSticky = |manIn[DROP_W-1:0];
  assign normExp    = expWide - (D_EXP_W+1)'(REBIAS);

  always_comb begin
    resVal    = '0;
    laneFlags = '0;
    if (expIn == '1) begin
      if (manIn == '0) begin
        resVal = {signBit, {S_EXP_W{1'b1}}, {S_MAN_W{1'b0}}};
      end else begin
        resVal = {signBit, {S_EXP_W{1'b1}}, 1'b1, manIn[D_MAN_W-2 -: S_MAN_W-1]};
        laneFlags.invalid = ~manIn[D_MAN_W-1];
      end
    end else if (expIn == '0 && manIn == '0) begin
      resVal = {signBit, {(S_W-1){1'b0}}};
    end else if (expWide >= (D_EXP_W+1)'(OVF_EXP)) begin
      resVal = {signBit, {(S_EXP_W-1){1'b1}}, 1'b0, {S_MAN_W{1'b1}}};
      laneFlags.overflow = 1'b1;
      laneFlags.inexact  = 1'b1;
    end else if (expWide > (D_EXP_W+1)'(REBIAS)) begin
      resVal = {signBit, normExp[S_EXP_W-1:0],
                manIn[D_MAN_W-1 -: S_MAN_W-1],
                manIn[DROP_W] | normSticky};
      laneFlags.inexact = normSticky;
    end else begin
      resVal = {signBit, {S_EXP_W{1'b0}}, subFrac[S_MAN_W-1:1], subFrac[0] | subSticky};
      laneFlags.inexact   = subSticky;
      laneFlags.underflow = subSticky;
    end
  end
endmodule

// File: rtl/narrow_ctrl.sv
module narrow_ctrl
  import rto_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  always_comb begin
    strobes            = '0;
    strobes.captureRes = inValid;
    strobes.accumFlags = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/narrow_datapath.sv
module narrow_datapath
  import rto_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] dstOld,
  input  logic             scalarMode,
  input  logic             upperHalf,
  input  logic             mergeScalar,
  output logic [VEC_W-1:0] dstOut,
  output fpFlags_t         flagsOut
);
  localparam int LANES = VEC_W / D_W;
  localparam int RES_W = LANES * S_W;
  localparam int FLG_W = $bits(fpFlags_t);

  logic [RES_W-1:0] resPacked;
  logic [LANES*FLG_W-1:0] flagsPacked;
  logic [VEC_W-1:0] nextDst;
  logic [FLG_W-1:0] opFlags;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fpFlags_t lf;
    fp_narrow_lane u_lane (
      .srcVal   (srcVec[g*D_W +: D_W]),
      .resVal   (resPacked[g*S_W +: S_W]),
      .laneFlags(lf)
    );
    assign flagsPacked[g*FLG_W +: FLG_W] = lf;
  end

  always_comb begin
    if (scalarMode) begin
      nextDst = mergeScalar ? dstOld : '0;
      nextDst[S_W-1:0] = resPacked[S_W-1:0];
      opFlags = flagsPacked[FLG_W-1:0];
    end else begin
      if (upperHalf) nextDst = {resPacked, dstOld[VEC_W-RES_W-1:0]};
      else           nextDst = {{(VEC_W-RES_W){1'b0}}, resPacked};
      opFlags = '0;
      for (int i = 0; i < LANES; i++) opFlags = opFlags | flagsPacked[i*FLG_W +: FLG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstOut   <= '0;
      flagsOut <= '0;
    end else begin
      if (strobes.captureRes) dstOut <= nextDst;
      if (strobes.accumFlags) flagsOut <= flagsOut | opFlags;
    end
  end
endmodule

// File: rtl/narrow_rto_unit.sv
module narrow_rto_unit
  import rto_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] dstOld,
  input  logic             scalarMode,
  input  logic             upperHalf,
  input  logic             mergeScalar,
  output logic             outValid,
  output logic [VEC_W-1:0] dstOut,
  output logic             flagInvalid,
  output logic             flagOverflow,
  output logic             flagUnderflow,
  output logic             flagInexact
);
  ctrlStrobes_t strobes;
  fpFlags_t     flags;

  narrow_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  narrow_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .srcVec     (srcVec),
    .dstOld     (dstOld),
    .scalarMode (scalarMode),
    .upperHalf  (upperHalf),
    .mergeScalar(mergeScalar),
    .dstOut     (dstOut),
    .flagsOut   (flags)
  );

  assign flagInvalid   = flags.invalid;
  assign flagOverflow  = flags.overflow;
  assign flagUnderflow = flags.underflow;
  assign flagInexact   = flags.inexact;
endmodule

// File: rtl/narrow_rto_chk.sv
module narrow_rto_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [VEC_W-1:0] dstOld,
  input logic             scalarMode,
  input logic             upperHalf,
  input logic             mergeScalar,
  input logic             outValid,
  input logic [VEC_W-1:0] dstOut,
  input logic             flagOverflow,
  input logic             flagUnderflow,
  input logic             flagInexact
);
  localparam int HALF = VEC_W / 2;

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R12
  hold_dst_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(dstOut));

  // R9
  lower_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !scalarMode && !upperHalf) |=> dstOut[VEC_W-1:HALF] == '0);

  // R10
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !scalarMode && upperHalf) |=> dstOut[HALF-1:0] == $past(dstOld[HALF-1:0]));

  // R11
  scalar_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && scalarMode && !mergeScalar) |=> dstOut[VEC_W-1:32] == '0);

  // R11
  scalar_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && scalarMode && mergeScalar) |=> dstOut[VEC_W-1:32] == $past(dstOld[VEC_W-1:32]));

  // R13
  sticky_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagInexact |=> flagInexact);

  // R4
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |-> flagInexact);

  // R5
  unf_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagUnderflow |-> flagInexact);
endmodule

bind narrow_rto_unit narrow_rto_chk #(.VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .dstOld       (dstOld),
  .scalarMode   (scalarMode),
  .upperHalf    (upperHalf),
  .mergeScalar  (mergeScalar),
  .outValid     (outValid),
  .dstOut       (dstOut),
  .flagOverflow (flagOverflow),
  .flagUnderflow(flagUnderflow),
  .flagInexact  (flagInexact)
);

// File: tb/sim_narrow_rto_unit.sv
module sim_narrow_rto_unit;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] srcVec = '0;
  logic [127:0] dstOld = '0;
  logic         scalarMode = 1'b0;
  logic         upperHalf = 1'b0;
  logic         mergeScalar = 1'b0;
  logic         outValid;
  logic [127:0] dstOut;
  logic         flagInvalid, flagOverflow, flagUnderflow, flagInexact;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  narrow_rto_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcVec(srcVec), .dstOld(dstOld),
    .scalarMode(scalarMode), .upperHalf(upperHalf), .mergeScalar(mergeScalar),
    .outValid(outValid), .dstOut(dstOut), .flagInvalid(flagInvalid),
    .flagOverflow(flagOverflow), .flagUnderflow(flagUnderflow), .flagInexact(flagInexact)
  );

  // flag nibble order: {invalid, overflow, underflow, inexact}
  localparam int NV = 22;
  localparam logic [99:0] VEC [NV] = '{
    {64'h3FF0000000000000, 32'h3F800000, 4'b0000}, // exact 1.0 (R3)
    {64'hC004000000000000, 32'hC0200000, 4'b0000}, // exact -2.5 (R3)
    {64'h47EFFFFFE0000000, 32'h7F7FFFFF, 4'b0000}, // largest finite (R3)
    {64'h3FF0000000000001, 32'h3F800001, 4'b0001}, // sticky forces lsb (R2)
    {64'h3FF0000020000000, 32'h3F800001, 4'b0000}, // lowest kept bit, exact (R3)
    {64'h3FF0000030000000, 32'h3F800001, 4'b0001}, // already odd + sticky (R2)
    {64'h3FFFFFFFFFFFFFFF, 32'h3FFFFFFF, 4'b0001}, // no round-up (R2)
    {64'h47F0000000000000, 32'h7F7FFFFF, 4'b0101}, // overflow (R4)
    {64'hC7F0000000000000, 32'hFF7FFFFF, 4'b0101}, // negative overflow (R4)
    {64'h3810000000000000, 32'h00800000, 4'b0000}, // min normal (R3)
    {64'h3800000000000000, 32'h00400000, 4'b0000}, // exact subnormal (R5)
    {64'h36A0000000000000, 32'h00000001, 4'b0000}, // 2^-149 exact (R5)
    {64'h36B8000000000000, 32'h00000003, 4'b0000}, // 3*2^-149 exact (R5)
    {64'h36A8000000000000, 32'h00000001, 4'b0011}, // inexact subnormal (R5)
    {64'h380FFFFFFFFFFFFF, 32'h007FFFFF, 4'b0011}, // just under min normal (R5)
    {64'h3690000000000000, 32'h00000001, 4'b0011}, // 2^-150 (R6)
    {64'h8000000000000001, 32'h80000001, 4'b0011}, // double subnormal (R6)
    {64'h7FF0000000000000, 32'h7F800000, 4'b0000}, // +inf (R8)
    {64'h8000000000000000, 32'h80000000, 4'b0000}, // -0 (R8)
    {64'h7FF8000000000000, 32'h7FC00000, 4'b0000}, // quiet NaN (R7)
    {64'hFFF4000000000000, 32'hFFE00000, 4'b1000}, // signaling NaN payload (R7)
    {64'h7FF0000000000001, 32'h7FC00000, 4'b1000}  // signaling NaN, low payload (R7)
  };

  function automatic string tagFor(logic [31:0] r, logic [3:0] f);
    if (r[30:23] == 8'hFF) return (r[22:0] != 0) ? "R7" : "R8";
    if (r[30:0] == 0) return "R8";
    if (f[2]) return "R4";
    if (r[30:23] == 8'h00) return (r[22:0] == 23'h1 && f[0] && r[31]) ? "R6" : "R5";
    return f[0] ? "R2" : "R3";
  endfunction

  task automatic check128(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dstOut actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkBits(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] flagNow();
    return {flagInvalid, flagOverflow, flagUnderflow, flagInexact};
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic doOp(logic [127:0] src, logic [127:0] old, logic sc, logic up, logic mg);
    @(negedge clk);
    srcVec = src; dstOld = old; scalarMode = sc; upperHalf = up; mergeScalar = mg;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [127:0] oldPat;
    oldPat = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;
    doReset();
    // R1 reset state
    check128("R1", dstOut, '0);
    checkBits("R1", "outValid/flags", {outValid, flagNow()}, 4'b0000);
    checkBits("R1", "outValid", {3'b0, outValid}, 4'b0);

    // table walk: both lanes carry the same value, vector lower placement (R9)
    for (int i = 0; i < NV; i++) begin
      logic [63:0] s;
      logic [31:0] r;
      logic [3:0]  f;
      s = VEC[i][99:36]; r = VEC[i][35:4]; f = VEC[i][3:0];
      doReset();
      doOp({s, s}, oldPat, 1'b0, 1'b0, 1'b0);
      check128(tagFor(r, f), dstOut, {64'h0, r, r});
      checkBits(tagFor(r, f), "flags", flagNow(), f);
    end

    // R9 distinct lanes, lane order
    doReset();
    doOp({64'hC004000000000000, 64'h3FF0000000000000}, oldPat, 1'b0, 1'b0, 1'b0);
    check128("R9", dstOut, {64'h0, 32'hC0200000, 32'h3F800000});

    // R10 upper placement keeps low half
    doOp({64'h7FF0000000000000, 64'h3810000000000000}, oldPat, 1'b0, 1'b1, 1'b0);
    check128("R10", dstOut, {32'h7F800000, 32'h00800000, oldPat[63:0]});

    // R12 valid timing and hold
    checkBits("R12", "outValid after op", {3'b0, outValid}, 4'b1);
    @(negedge clk);
    checkBits("R12", "outValid idle", {3'b0, outValid}, 4'b0);
    check128("R12", dstOut, {32'h7F800000, 32'h00800000, oldPat[63:0]});

    // R11 scalar without merge; lane 1 is a signaling NaN that must be ignored
    doReset();
    doOp({64'h7FF0000000000001, 64'hC004000000000000}, oldPat, 1'b1, 1'b1, 1'b0);
    check128("R11", dstOut, {96'h0, 32'hC0200000});
    checkBits("R11", "flags", flagNow(), 4'b0000);

    // R11 scalar with merge
    doOp({64'h47F0000000000000, 64'h3FF0000000000001}, oldPat, 1'b1, 1'b0, 1'b1);
    check128("R11", dstOut, {oldPat[127:32], 32'h3F800001});
    checkBits("R11", "flags", flagNow(), 4'b0001);

    // R13 flags accumulate across operations
    doOp({64'h3FF0000000000000, 64'h47F0000000000000}, oldPat, 1'b0, 1'b0, 1'b0);
    checkBits("R13", "flags", flagNow(), 4'b0101);
    doOp({64'h3FF0000000000000, 64'h3FF0000000000000}, oldPat, 1'b0, 1'b0, 1'b0);
    checkBits("R13", "flags after exact op", flagNow(), 4'b0101);
    doOp({64'h7FF4000000000000, 64'h3690000000000000}, oldPat, 1'b0, 1'b0, 1'b0);
    checkBits("R13", "flags", flagNow(), 4'b1111);
    doReset();
    checkBits("R13", "flags after reset", flagNow(), 4'b0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule